// File: doc/BRIEF.md
# Synchronous Trap Return-Address Adjuster

This block sits beside the execute stage of a 16-bit core that has a 4-bit page extension. It watches each instruction as it executes and raises a trap request in two cases. The first is an opcode that decodes to no defined operation. The second is the background-debug entry instruction issued while debug mode is switched off.

Because the fetch pipeline runs ahead, the 20-bit page:PC seen during execution is 6 past the faulting instruction. The common return path always takes 6 away. The block therefore adds 2 to the whole page:PC before the exception sequencer stacks it, so that execution resumes at the instruction after the faulting one. Asynchronous interrupt entries pass their page:PC to the same stacking register with no change.

Once a trap fires, the block holds interrupt recognition off until the handler has been entered and its first instruction has retired. Stacking and vector fetch belong to the exception sequencer, which consumes the outputs of this block.

Top module: `sync_trap_adjust`

## Requirements
- R1: When `exec_vld` is 1 and `op_defined` is 0 in a cycle, `trap_req` is 1 in the following cycle.
- R2: When `exec_vld` and `bgd_op` are 1 and `dbg_en` is 0, `trap_req` is 1 in the following cycle. With `dbg_en` 1, a defined `bgd_op` raises no trap.
- R3: A cycle where the opcode is both undefined and a disabled debug instruction gives one single-cycle `trap_req` pulse. `trap_req` is never high in a cycle that follows one with no trap condition.
- R4: On a trap, `stack_pc` becomes the sampled `pc_in` plus 2, modulo 2^20. A carry out of the low 16 bits increments the upper 4-bit page field.
- R5: On an `irq_entry` cycle with no trap condition, `stack_pc` becomes the sampled `pc_in` unchanged.
- R6: When a trap condition and `irq_entry` occur in the same cycle, the trap wins and `stack_pc` gets the +2 value.
- R7: In a cycle with neither a trap condition nor `irq_entry`, `stack_pc` keeps its value.
- R8: `irq_inhibit` is 1 in the same cycle as `trap_req`. It stays 1 while the handler has not yet been loaded, and any `retire` pulses in that interval do not release it.
- R9: `irq_inhibit` falls in the cycle after the first `retire` pulse that comes strictly after the cycle in which `handler_load` is 1. A `retire` in the same cycle as `handler_load` does not count.
- R10: While `rst` is 1 at a clock edge, `trap_req`, `irq_inhibit` and `stack_pc` are cleared to 0 after that edge.
- R11: With `exec_vld` 0, no trap is raised, whatever the values of `op_defined`, `bgd_op` and `dbg_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_vld | input | 1 | An instruction is in execute this cycle |
| op_defined | input | 1 | The decoded opcode maps to a defined instruction |
| bgd_op | input | 1 | The instruction is the background-debug entry |
| dbg_en | input | 1 | Background debug mode is enabled |
| irq_entry | input | 1 | Asynchronous interrupt entry is taken this cycle |
| handler_load | input | 1 | The handler address is being loaded into the PC |
| retire | input | 1 | An instruction retires this cycle |
| pc_in | input | 20 | Pipelined page:PC (page in bits 19:16) |
| trap_req | output | 1 | Single-cycle illegal-instruction trap request |
| stack_pc | output | 20 | Page:PC value to be stacked |
| irq_inhibit | output | 1 | Interrupt recognition held off |

## Verification
Assertions watch every cycle for the single-cycle cause-to-request relation of both trap causes and the absence of traps with no instruction in execute. They also cover the +2, pass-through and hold choices for the stacking register, and check that inhibit is high whenever a request is and drops only just after a retire. The bench scenarios are needed for the rest: the page-carry boundaries, a trap colliding with an interrupt entry, and the rule that a retire before the handler load, or in the same cycle as it, leaves inhibit high.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int unsigned PAGE_W = 4;
    localparam int unsigned OFF_W  = 16;
    localparam int unsigned PPC_W  = PAGE_W + OFF_W;

    typedef logic [PPC_W-1:0] ppc_t;

    typedef enum logic [1:0] {
        HS_IDLE        = 2'd0,
        HS_WAIT_LOAD   = 2'd1,
        HS_WAIT_RETIRE = 2'd2
    } hold_state_e;

    typedef struct packed {
        logic undef_op;
        logic bgd_off;
    } trap_cause_t;

    function automatic ppc_t adj_ppc(input ppc_t pc, input int unsigned step);
        return ppc_t'(pc + ppc_t'(step));
    endfunction
endpackage

// File: rtl/trap_detect.sv
module trap_detect
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic exec_vld,
    input  logic op_defined,
    input  logic bgd_op,
    input  logic dbg_en,
    output logic trap_hit,
    output logic trap_req
);
    trap_cause_t cause;

    always_comb begin
        cause.undef_op = !op_defined;
        cause.bgd_off  = bgd_op && !dbg_en;
        trap_hit       = exec_vld && (|cause);
    end

    always_ff @(posedge clk) begin
        if (rst) trap_req <= 1'b0;
        else     trap_req <= trap_hit;
    end

    p_undef_trap_r1: assert property (@(posedge clk) disable iff (rst)
        exec_vld && !op_defined |=> trap_req);
    p_bgd_trap_r2: assert property (@(posedge clk) disable iff (rst)
        exec_vld && bgd_op && !dbg_en |=> trap_req);
    p_no_exec_r11: assert property (@(posedge clk) disable iff (rst)
        !exec_vld |=> !trap_req);
    p_defined_ok_r3: assert property (@(posedge clk) disable iff (rst)
        op_defined && !(bgd_op && !dbg_en) |=> !trap_req);
endmodule

// File: rtl/retaddr_adjust.sv
module retaddr_adjust
    import trap_pkg::*;
#(
    parameter int unsigned RET_ADJ = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trap_hit,
    input  logic irq_entry,
    input  ppc_t pc_in,
    output ppc_t stack_pc
);
    ppc_t pc_next;

    always_comb begin
        if (trap_hit)       pc_next = adj_ppc(pc_in, RET_ADJ);
        else if (irq_entry) pc_next = pc_in;
        else                pc_next = stack_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) stack_pc <= '0;
        else     stack_pc <= pc_next;
    end

    p_adj_r4: assert property (@(posedge clk) disable iff (rst)
        trap_hit |=> stack_pc == ppc_t'($past(pc_in) + ppc_t'(RET_ADJ)));
    p_pass_r5: assert property (@(posedge clk) disable iff (rst)
        irq_entry && !trap_hit |=> stack_pc == $past(pc_in));
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !irq_entry && !trap_hit |=> $stable(stack_pc));
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trap_hit,
    input  logic handler_load,
    input  logic retire,
    output logic irq_inhibit
);
    hold_state_e state, state_next;

    always_comb begin
        state_next = state;
        if (trap_hit) begin
            state_next = HS_WAIT_LOAD;
        end else begin
            unique case (state)
                HS_WAIT_LOAD:   if (handler_load) state_next = HS_WAIT_RETIRE;
                HS_WAIT_RETIRE: if (retire)       state_next = HS_IDLE;
                default:        state_next = HS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= HS_IDLE;
        else     state <= state_next;
    end

    assign irq_inhibit = (state != HS_IDLE);

    p_set_r8: assert property (@(posedge clk) disable iff (rst)
        trap_hit |=> irq_inhibit);
    p_wait_load_r8: assert property (@(posedge clk) disable iff (rst)
        state == HS_WAIT_LOAD && !trap_hit |=> irq_inhibit);
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_inhibit) |-> $past(retire) && $past(state) == HS_WAIT_RETIRE);
endmodule

// File: rtl/sync_trap_adjust.sv
module sync_trap_adjust
    import trap_pkg::*;
#(
    parameter int unsigned RET_ADJ = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exec_vld,
    input  logic             op_defined,
    input  logic             bgd_op,
    input  logic             dbg_en,
    input  logic             irq_entry,
    input  logic             handler_load,
    input  logic             retire,
    input  logic [PPC_W-1:0] pc_in,
    output logic             trap_req,
    output logic [PPC_W-1:0] stack_pc,
    output logic             irq_inhibit
);
    logic trap_hit;

    trap_detect u_detect (
        .clk        (clk),
        .rst        (rst),
        .exec_vld   (exec_vld),
        .op_defined (op_defined),
        .bgd_op     (bgd_op),
        .dbg_en     (dbg_en),
        .trap_hit   (trap_hit),
        .trap_req   (trap_req)
    );

    retaddr_adjust #(.RET_ADJ(RET_ADJ)) u_adjust (
        .clk       (clk),
        .rst       (rst),
        .trap_hit  (trap_hit),
        .irq_entry (irq_entry),
        .pc_in     (pc_in),
        .stack_pc  (stack_pc)
    );

    irq_holdoff u_holdoff (
        .clk          (clk),
        .rst          (rst),
        .trap_hit     (trap_hit),
        .handler_load (handler_load),
        .retire       (retire),
        .irq_inhibit  (irq_inhibit)
    );

    p_req_inhibit_r8: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> irq_inhibit);
    p_reset_r10: assert property (@(posedge clk)
        rst |=> !trap_req && !irq_inhibit && stack_pc == '0);
endmodule

// File: tb/sync_trap_adjust_bench.sv
module sync_trap_adjust_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_vld = 0, op_defined = 1, bgd_op = 0, dbg_en = 0;
    logic        irq_entry = 0, handler_load = 0, retire = 0;
    logic [19:0] pc_in = '0;
    logic        trap_req, irq_inhibit;
    logic [19:0] stack_pc;

    int checks = 0;
    int fails  = 0;

    logic        m_trap = 0;
    logic [19:0] m_pc = '0;
    int          m_state = 0;

    always #5 clk = ~clk;

    sync_trap_adjust u_sync_trap_adjust (
        .clk(clk), .rst(rst), .exec_vld(exec_vld), .op_defined(op_defined),
        .bgd_op(bgd_op), .dbg_en(dbg_en), .irq_entry(irq_entry),
        .handler_load(handler_load), .retire(retire), .pc_in(pc_in),
        .trap_req(trap_req), .stack_pc(stack_pc), .irq_inhibit(irq_inhibit)
    );

    function automatic logic exp_hit(logic e, logic od, logic bg, logic de);
        return e && (!od || (bg && !de));
    endfunction

    function automatic logic [19:0] exp_adj(logic [19:0] pc);
        return pc + 20'd2;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic e, logic od, logic bg, logic de, logic ir,
                       logic hl, logic rt, logic [19:0] pc);
        logic hit;
        exec_vld = e; op_defined = od; bgd_op = bg; dbg_en = de;
        irq_entry = ir; handler_load = hl; retire = rt; pc_in = pc;
        hit = exp_hit(e, od, bg, de);
        m_trap = hit;
        if (hit)     m_pc = exp_adj(pc);
        else if (ir) m_pc = pc;
        if (hit) m_state = 1;
        else if (m_state == 1 && hl) m_state = 2;
        else if (m_state == 2 && rt) m_state = 0;
        @(posedge clk);
        #1;
        chk("R1 R2 R3 trap_req model", 32'(trap_req), 32'(m_trap));
        chk("R4 R5 R7 stack_pc model", 32'(stack_pc), 32'(m_pc));
        chk("R8 R9 irq_inhibit model", 32'(irq_inhibit), 32'(m_state != 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(posedge clk);
        #1;
        chk("R10 trap_req after reset", 32'(trap_req), 0);
        chk("R10 irq_inhibit after reset", 32'(irq_inhibit), 0);
        chk("R10 stack_pc after reset", 32'(stack_pc), 0);
        rst = 0;

        cyc(1, 0, 0, 0, 0, 0, 0, 20'h12340);
        chk("R1 undefined opcode trap", 32'(trap_req), 1);
        chk("R4 plain +2", 32'(stack_pc), 32'h12342);

        cyc(1, 0, 0, 0, 0, 0, 0, 20'h3FFFE);
        chk("R4 page carry", 32'(stack_pc), 32'h40000);
        cyc(1, 0, 0, 0, 0, 0, 0, 20'hFFFFF);
        chk("R4 wrap at 2^20", 32'(stack_pc), 32'h00001);

        cyc(1, 1, 1, 0, 0, 0, 0, 20'h00200);
        chk("R2 debug op with debug off", 32'(trap_req), 1);
        cyc(1, 1, 1, 1, 0, 0, 0, 20'h00300);
        chk("R2 debug op with debug on", 32'(trap_req), 0);
        chk("R7 stack_pc held", 32'(stack_pc), 32'h00202);

        cyc(0, 0, 1, 0, 0, 0, 0, 20'h00400);
        chk("R11 no exec no trap", 32'(trap_req), 0);

        cyc(1, 0, 1, 0, 0, 0, 0, 20'h00010);
        chk("R3 both causes one request", 32'(trap_req), 1);
        cyc(0, 1, 0, 0, 0, 0, 0, 20'h00020);
        chk("R3 single cycle pulse", 32'(trap_req), 0);

        cyc(0, 1, 0, 0, 1, 0, 0, 20'h5ABCD);
        chk("R5 interrupt pass-through", 32'(stack_pc), 32'h5ABCD);
        cyc(1, 0, 0, 0, 1, 0, 0, 20'h7FFFF);
        chk("R6 trap beats interrupt", 32'(stack_pc), 32'h80001);
        chk("R8 inhibit with request", 32'(irq_inhibit), 1);

        cyc(0, 1, 0, 0, 0, 0, 1, 20'h0);
        chk("R8 early retire ignored", 32'(irq_inhibit), 1);
        cyc(0, 1, 0, 0, 0, 1, 1, 20'h0);
        chk("R9 retire with load ignored", 32'(irq_inhibit), 1);
        cyc(0, 1, 0, 0, 0, 0, 0, 20'h0);
        chk("R9 waiting for retire", 32'(irq_inhibit), 1);
        cyc(0, 1, 0, 0, 0, 0, 1, 20'h0);
        chk("R9 release after retire", 32'(irq_inhibit), 0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] | r[1], (r[4:2] != 0), (r[7:5] == 0), r[8], (r[11:9] == 0),
                (r[14:12] == 0), (r[16:15] == 0), 20'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule